// File: doc/BRIEF.md
# Lockstep Compare and Checkpoint Recovery Unit

This block sits between two identical copies of a processor's execution units and the master copy of the architected register state. Each copy presents one register update per cycle: a valid flag, an address in a register space of `ADDR_W` bits, 64 bits of data and a completion strobe that marks the last update of an instruction. The block compares the two copies. It holds the updates of the current instruction in a small buffer. When the instruction completes, it writes them one per cycle into a checkpoint array protected by SECDED coding. Each write is also broadcast, so local register copies elsewhere track the master copy.

When the copies disagree, the buffer overflows or an external error is raised, the block stops all checkpoint writes in that same cycle and throws away every buffered entry that has not yet been written. It then runs a hardware recovery sequence in four steps. It asks for completed stores to be drained. It asks for caches and translation buffers to be purged. It asks for the pipeline controls to be reset. Last, it reads every checkpoint entry in ascending address order, corrects it, writes it back and broadcasts it. At the end it sets an interrupt pending and emits a one-cycle log record. A step that is not acknowledged in time, or an entry that cannot be corrected, stops the machine with a sticky checkstop. An injection control can force miscompares, on command or at pseudo-random times, and can corrupt checkpoint writes in order to exercise the coding.

Top module: `lockstep_ckpt_unit`

## Requirements
- R1: In the idle state, any difference between the copies is a miscompare: valid flags differ, completion strobes differ, or both are valid with a different address or data. `drain_req` rises in the cycle after the miscompare is sampled.
- R2: A matching valid update is not written or broadcast before its instruction completes. Completion is a cycle in which both strobes are high, and an update in that same cycle belongs to the completing instruction. After completion the buffered updates are written and broadcast on `bc_*` one per cycle, oldest first, starting in the second cycle after the completion edge.
- R3: Each checkpoint entry is stored as a 72-bit SECDED code word. The replay broadcast for an address carries the data last committed to it, and every entry is zero after reset.
- R4: An error blocks the checkpoint write of the cycle in which it is sampled. It discards every buffered entry not yet written, including entries of an instruction that has already completed. None of those entries is ever broadcast.
- R5: Recovery raises `drain_req`, then `purge_req`, then `reset_req`, at most one at a time. Each request is held until its acknowledge is sampled, and the next request rises in the cycle after that acknowledge.
- R6: After `reset_ack`, replay broadcasts every address from 0 to 2^ADDR_W-1 in ascending order, one per cycle, with no gap.
- R7: The cycle after the last replay broadcast, `log_vld` pulses for one cycle and `irq_pend` is set. `log_cause` gives bit 0 = miscompare (including a forced one), bit 1 = external error, bit 2 = overflow. `log_corr` gives the number of entries corrected during this replay. `irq_clr` clears `irq_pend`.
- R8: At most `BUF_DEPTH` updates fit in one instruction. A further matching update before completion is an overflow error. Exactly `BUF_DEPTH` updates with the completion on the last one commit normally.
- R9: A recovery step whose acknowledge has not arrived after `TIMEOUT` cycles raises `checkstop`. `checkstop` is sticky until reset, and no further request is made.
- R10: A single-bit error in an entry is corrected during replay. The corrected data is broadcast and the fixed word is written back, so a later replay counts no correction for that entry.
- R11: A double-bit error found during replay raises `checkstop` without broadcasting that entry or any later one.
- R12: `inj_mode` values: 0 off; 1 forces a miscompare in each idle cycle with `inj_fire` high; 2 forces a miscompare whenever the low `RAND_W` bits of a free-running 16-bit LFSR are zero; 3 flips code bit 3 of each checkpoint write made while `inj_fire` is high; 4 flips code bits 3 and 5 of each such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_a_vld | input | 1 | Copy A update valid |
| upd_a_addr | input | ADDR_W | Copy A register address |
| upd_a_data | input | 64 | Copy A register data |
| upd_a_cmpl | input | 1 | Copy A instruction completion |
| upd_b_vld | input | 1 | Copy B update valid |
| upd_b_addr | input | ADDR_W | Copy B register address |
| upd_b_data | input | 64 | Copy B register data |
| upd_b_cmpl | input | 1 | Copy B instruction completion |
| ext_err | input | 1 | Error raised elsewhere in the processor |
| inj_mode | input | 3 | Error injection mode |
| inj_fire | input | 1 | Injection trigger |
| drain_req | output | 1 | Request to drain completed stores |
| drain_ack | input | 1 | Store drain done |
| purge_req | output | 1 | Request to purge caches and translation buffers |
| purge_ack | input | 1 | Purge done |
| reset_req | output | 1 | Request to reset pipeline controls |
| reset_ack | input | 1 | Pipeline reset done |
| bc_vld | output | 1 | Broadcast write valid |
| bc_addr | output | ADDR_W | Broadcast register address |
| bc_data | output | 64 | Broadcast register data |
| irq_pend | output | 1 | Recovery interrupt pending |
| irq_clr | input | 1 | Clears the pending interrupt |
| log_vld | output | 1 | Log record valid (one cycle) |
| log_cause | output | 3 | Error cause bits of the log record |
| log_corr | output | ADDR_W+1 | Entries corrected during replay |
| checkstop | output | 1 | Sticky fatal stop |

## Verification
The bench builds the unit with `ADDR_W` = 4, which makes a replay sixteen broadcasts long. Each recovery's full event stream can therefore be compared against a model of all sixteen entries, and a double-bit error can be placed in the middle of a replay. `TIMEOUT` = 20 lets a withheld acknowledge reach checkstop within a few dozen cycles, and a check some cycles earlier shows it has not fired yet. `RAND_W` = 3 makes pseudo-random miscompares frequent enough to occur within a short window. `BUF_DEPTH` keeps its default of 8, so the eight-update boundary and the ninth-update overflow are the ones the unit ships with.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;
    localparam int DATA_W  = 64;
    localparam int PAR_W   = 7;
    localparam int CODE_W  = DATA_W + PAR_W + 1;
    localparam int CAUSE_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DRAIN, ST_PURGE, ST_RESET, ST_REPLAY, ST_STOP
    } rec_state_e;

    typedef enum logic [2:0] {
        INJ_OFF = 3'd0, INJ_PULSE = 3'd1, INJ_RANDOM = 3'd2,
        INJ_FLIP1 = 3'd3, INJ_FLIP2 = 3'd4
    } inj_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sbe;
        logic              dbe;
    } dec_t;

    // Hamming positions 1..71 in bits 71:1, overall parity in bit 0.
    function automatic logic [CODE_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        logic x;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[j];
                j++;
            end
        end
        for (int k = 0; k < PAR_W; k++) begin
            x = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (((p >> k) & 1) == 1 && p != (1 << k)) x = x ^ c[p];
            end
            c[1 << k] = x;
        end
        c[0] = ^c[CODE_W-1:1];
        return c;
    endfunction

    function automatic dec_t secded_dec(input logic [CODE_W-1:0] cw);
        dec_t r;
        logic [PAR_W-1:0] s;
        logic [CODE_W-1:0] c;
        logic o;
        int j;
        s = '0;
        c = cw;
        o = ^cw;
        for (int k = 0; k < PAR_W; k++) begin
            for (int p = 1; p < CODE_W; p++) begin
                if (((p >> k) & 1) == 1) s[k] = s[k] ^ cw[p];
            end
        end
        r.sbe = o && (s < PAR_W'(CODE_W));
        r.dbe = (!o && s != '0) || (o && s >= PAR_W'(CODE_W));
        for (int p = 0; p < CODE_W; p++) begin
            if (r.sbe && s == PAR_W'(p)) c[p] = ~c[p];
        end
        r.data = '0;
        j = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                r.data[j] = c[p];
                j++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/lsr_cmp.sv
`timescale 1ns/1ps
module lsr_cmp #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              a_vld,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_cmpl,
    input  logic              b_vld,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_cmpl,
    output logic              mis
);
    logic field_diff;

    always_comb begin
        field_diff = (a_addr != b_addr) || (a_data != b_data);
        mis = (a_vld != b_vld) || (a_cmpl != b_cmpl) || (a_vld && field_diff);
    end
endmodule

// File: rtl/lsr_inject.sv
`timescale 1ns/1ps
module lsr_inject
    import lsr_pkg::*;
#(
    parameter int RAND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              fire,
    output logic              force_mis,
    output logic [CODE_W-1:0] wflip
);
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] SEED = 16'hACE1;

    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[LFSR_W-2:0],
                  lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
        force_mis = (mode == INJ_PULSE && fire)
                 || (mode == INJ_RANDOM && lfsr_q[RAND_W-1:0] == '0);
        wflip = '0;
        if (fire && (mode == INJ_FLIP1 || mode == INJ_FLIP2)) wflip[3] = 1'b1;
        if (fire && mode == INJ_FLIP2) wflip[5] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end
endmodule

// File: rtl/lsr_ckpt_mem.sv
`timescale 1ns/1ps
module lsr_ckpt_mem
    import lsr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CODE_W-1:0] wflip,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rsbe,
    output logic              rdbe
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CODE_W-1:0] mem_q [DEPTH];
    dec_t              rd_dec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= secded_enc(wdata) ^ wflip;
        end
    end

    always_comb begin
        rd_dec = secded_dec(mem_q[raddr]);
        rdata  = rd_dec.data;
        rsbe   = rd_dec.sbe;
        rdbe   = rd_dec.dbe;
    end
endmodule

// File: rtl/lockstep_ckpt_unit.sv
`timescale 1ns/1ps
module lockstep_ckpt_unit
    import lsr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUF_DEPTH = 8,
    parameter int TIMEOUT   = 1024,
    parameter int RAND_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_a_vld,
    input  logic [ADDR_W-1:0]  upd_a_addr,
    input  logic [63:0]        upd_a_data,
    input  logic               upd_a_cmpl,
    input  logic               upd_b_vld,
    input  logic [ADDR_W-1:0]  upd_b_addr,
    input  logic [63:0]        upd_b_data,
    input  logic               upd_b_cmpl,
    input  logic               ext_err,
    input  logic [2:0]         inj_mode,
    input  logic               inj_fire,
    output logic               drain_req,
    input  logic               drain_ack,
    output logic               purge_req,
    input  logic               purge_ack,
    output logic               reset_req,
    input  logic               reset_ack,
    output logic               bc_vld,
    output logic [ADDR_W-1:0]  bc_addr,
    output logic [63:0]        bc_data,
    output logic               irq_pend,
    input  logic               irq_clr,
    output logic               log_vld,
    output logic [2:0]         log_cause,
    output logic [ADDR_W:0]    log_corr,
    output logic               checkstop
);
    localparam int NENT  = 1 << ADDR_W;
    localparam int ENT_W = ADDR_W + DATA_W;
    localparam int PTR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
    localparam int CNT_W = $clog2(BUF_DEPTH + 1);
    localparam int TMR_W = $clog2(TIMEOUT + 1);

    typedef struct packed {
        rec_state_e                      st;
        logic [BUF_DEPTH-1:0][ENT_W-1:0] fifo;
        logic [PTR_W-1:0]                rd;
        logic [PTR_W-1:0]                wr;
        logic [CNT_W-1:0]                cmt;
        logic [CNT_W-1:0]                pend;
        logic [TMR_W-1:0]                tmr;
        logic [ADDR_W-1:0]               idx;
        logic [ADDR_W:0]                 corr;
        logic [CAUSE_W-1:0]              cause;
        logic                            bc_vld;
        logic [ADDR_W-1:0]               bc_addr;
        logic [DATA_W-1:0]               bc_data;
        logic                            irq;
        logic                            log_vld;
    } state_t;

    state_t s_d, s_q;
    rec_state_e cur_st;

    logic              mis, force_mis, mis_any, push, pop, ovf, err, cmpl, step_ack;
    logic              mem_we, rd_sbe, rd_dbe;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_wdata, rd_data;
    logic [CODE_W-1:0] wflip;
    rec_state_e        step_next;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(BUF_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    lsr_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .a_vld(upd_a_vld), .a_addr(upd_a_addr), .a_data(upd_a_data), .a_cmpl(upd_a_cmpl),
        .b_vld(upd_b_vld), .b_addr(upd_b_addr), .b_data(upd_b_data), .b_cmpl(upd_b_cmpl),
        .mis(mis)
    );

    lsr_inject #(.RAND_W(RAND_W)) u_inj (
        .clk(clk), .rst_n(rst_n), .mode(inj_mode), .fire(inj_fire),
        .force_mis(force_mis), .wflip(wflip)
    );

    lsr_ckpt_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .wflip(wflip), .raddr(mem_raddr), .rdata(rd_data), .rsbe(rd_sbe), .rdbe(rd_dbe)
    );

    always_comb begin
        s_d        = s_q;
        s_d.bc_vld = 1'b0;
        s_d.log_vld = 1'b0;

        mis_any = mis || force_mis;
        cmpl    = upd_a_cmpl && !mis_any;
        push    = upd_a_vld && !mis_any;
        ovf     = push && (s_q.pend == CNT_W'(BUF_DEPTH));
        err     = mis_any || ext_err || ovf;
        pop     = 1'b0;

        mem_we    = 1'b0;
        mem_waddr = s_q.fifo[s_q.rd][ENT_W-1:DATA_W];
        mem_wdata = s_q.fifo[s_q.rd][DATA_W-1:0];
        mem_raddr = s_q.idx;

        case (s_q.st)
            ST_DRAIN: begin step_ack = drain_ack; step_next = ST_PURGE;  end
            ST_PURGE: begin step_ack = purge_ack; step_next = ST_RESET;  end
            default:  begin step_ack = reset_ack; step_next = ST_REPLAY; end
        endcase

        if (irq_clr) s_d.irq = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (err) begin
                    s_d.st    = ST_DRAIN;
                    s_d.tmr   = '0;
                    s_d.cmt   = '0;
                    s_d.pend  = '0;
                    s_d.rd    = '0;
                    s_d.wr    = '0;
                    s_d.corr  = '0;
                    s_d.cause = {ovf, ext_err, mis_any};
                end else begin
                    pop = (s_q.cmt != '0);
                    if (pop) begin
                        mem_we      = 1'b1;
                        s_d.bc_vld  = 1'b1;
                        s_d.bc_addr = mem_waddr;
                        s_d.bc_data = mem_wdata;
                        s_d.rd      = ptr_inc(s_q.rd);
                    end
                    if (push) begin
                        s_d.fifo[s_q.wr] = {upd_a_addr, upd_a_data};
                        s_d.wr = ptr_inc(s_q.wr);
                    end
                    s_d.cmt  = s_q.cmt - CNT_W'(pop)
                             + (cmpl ? s_q.pend + CNT_W'(push) : '0);
                    s_d.pend = cmpl ? '0 : s_q.pend + CNT_W'(push);
                end
            end
            ST_DRAIN, ST_PURGE, ST_RESET: begin
                if (step_ack) begin
                    s_d.st  = step_next;
                    s_d.tmr = '0;
                    s_d.idx = '0;
                end else if (s_q.tmr == TMR_W'(TIMEOUT - 1)) begin
                    s_d.st = ST_STOP;
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
            end
            ST_REPLAY: begin
                if (rd_dbe) begin
                    s_d.st = ST_STOP;
                end else begin
                    mem_we      = 1'b1;
                    mem_waddr   = s_q.idx;
                    mem_wdata   = rd_data;
                    s_d.bc_vld  = 1'b1;
                    s_d.bc_addr = s_q.idx;
                    s_d.bc_data = rd_data;
                    if (rd_sbe) s_d.corr = s_q.corr + 1'b1;
                    if (s_q.idx == ADDR_W'(NENT - 1)) begin
                        s_d.st      = ST_IDLE;
                        s_d.log_vld = 1'b1;
                        s_d.irq     = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_st    = s_q.st;
    assign drain_req = (cur_st == ST_DRAIN);
    assign purge_req = (cur_st == ST_PURGE);
    assign reset_req = (cur_st == ST_RESET);
    assign checkstop = (cur_st == ST_STOP);
    assign bc_vld    = s_q.bc_vld;
    assign bc_addr   = s_q.bc_addr;
    assign bc_data   = s_q.bc_data;
    assign irq_pend  = s_q.irq;
    assign log_vld   = s_q.log_vld;
    assign log_cause = s_q.cause;
    assign log_corr  = s_q.corr;
endmodule

// File: rtl/lsr_chk.sv
`timescale 1ns/1ps
module lsr_chk
    import lsr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       upd_a_vld,
    input logic       upd_b_vld,
    input logic       drain_req,
    input logic       drain_ack,
    input logic       purge_req,
    input logic       purge_ack,
    input logic       reset_req,
    input logic       bc_vld,
    input logic       irq_pend,
    input logic       log_vld,
    input logic       checkstop,
    input rec_state_e st
);
    // R1
    vld_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && upd_a_vld != upd_b_vld) |=> drain_req);

    // R5
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drain_req, purge_req, reset_req}));

    // R5
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && !drain_ack) |=> (drain_req || checkstop));

    // R5
    drain_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && drain_ack) |=> purge_req);

    // R5
    purge_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_req && purge_ack) |=> reset_req);

    // R9
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |=> checkstop);

    // R11
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |-> (!bc_vld && !drain_req && !log_vld));

    // R7
    log_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_vld |-> irq_pend);
endmodule

bind lockstep_ckpt_unit lsr_chk u_lsr_chk (
    .clk(clk), .rst_n(rst_n), .upd_a_vld(upd_a_vld), .upd_b_vld(upd_b_vld),
    .drain_req(drain_req), .drain_ack(drain_ack), .purge_req(purge_req),
    .purge_ack(purge_ack), .reset_req(reset_req), .bc_vld(bc_vld),
    .irq_pend(irq_pend), .log_vld(log_vld), .checkstop(checkstop), .st(cur_st)
);

// File: tb/lockstep_ckpt_unit_test.sv
`timescale 1ns/1ps
module lockstep_ckpt_unit_test;
    localparam int AW   = 4;
    localparam int NE   = 1 << AW;
    localparam int TOUT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_vld = 0, a_cmpl = 0, b_vld = 0, b_cmpl = 0, ext_err = 0, inj_fire = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [63:0] a_data = '0, b_data = '0;
    logic [2:0] inj_mode = 3'd0;
    logic drain_req, purge_req, reset_req, drain_ack, purge_ack, reset_ack;
    logic bc_vld, irq_pend, irq_clr = 0, log_vld, checkstop;
    logic [AW-1:0] bc_addr;
    logic [63:0] bc_data;
    logic [2:0] log_cause;
    logic [AW:0] log_corr;

    int ncheck = 0, nfail = 0;
    bit done = 0;
    bit ack_on = 1;
    logic [63:0] model [NE];

    int ev_n = 0;
    int ev_kind [256];
    int ev_addr [256];
    logic [63:0] ev_data [256];
    bit log_seen = 0;
    logic [2:0] log_cause_c;
    int log_corr_c;

    always #2.5 clk = ~clk;

    lockstep_ckpt_unit #(.ADDR_W(AW), .BUF_DEPTH(8), .TIMEOUT(TOUT), .RAND_W(3)) uut (
        .clk(clk), .rst_n(rst_n),
        .upd_a_vld(a_vld), .upd_a_addr(a_addr), .upd_a_data(a_data), .upd_a_cmpl(a_cmpl),
        .upd_b_vld(b_vld), .upd_b_addr(b_addr), .upd_b_data(b_data), .upd_b_cmpl(b_cmpl),
        .ext_err(ext_err), .inj_mode(inj_mode), .inj_fire(inj_fire),
        .drain_req(drain_req), .drain_ack(drain_ack), .purge_req(purge_req),
        .purge_ack(purge_ack), .reset_req(reset_req), .reset_ack(reset_ack),
        .bc_vld(bc_vld), .bc_addr(bc_addr), .bc_data(bc_data),
        .irq_pend(irq_pend), .irq_clr(irq_clr), .log_vld(log_vld),
        .log_cause(log_cause), .log_corr(log_corr), .checkstop(checkstop)
    );

    // acknowledge responder: answers each request after two cycles
    initial begin
        int wcnt;
        wcnt = 0;
        drain_ack = 0; purge_ack = 0; reset_ack = 0;
        forever begin
            @(negedge clk);
            drain_ack = 0; purge_ack = 0; reset_ack = 0;
            if (ack_on && (drain_req || purge_req || reset_req)) begin
                if (wcnt == 2) begin
                    drain_ack = drain_req; purge_ack = purge_req; reset_ack = reset_req;
                    wcnt = 0;
                end else wcnt++;
            end else wcnt = 0;
        end
    end

    // event monitor
    initial begin
        bit pd, pp, pr;
        pd = 0; pp = 0; pr = 0;
        forever begin
            @(negedge clk);
            if (ev_n < 250) begin
                if (drain_req && !pd) begin ev_kind[ev_n] = 1; ev_n++; end
                if (purge_req && !pp) begin ev_kind[ev_n] = 2; ev_n++; end
                if (reset_req && !pr) begin ev_kind[ev_n] = 3; ev_n++; end
                if (bc_vld) begin
                    ev_kind[ev_n] = 4; ev_addr[ev_n] = int'(bc_addr); ev_data[ev_n] = bc_data; ev_n++;
                end
            end
            if (log_vld) begin log_seen = 1; log_cause_c = log_cause; log_corr_c = int'(log_corr); end
            pd = drain_req; pp = purge_req; pr = reset_req;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        ncheck++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic av, input logic [AW-1:0] aa, input logic [63:0] ad, input logic ac,
                       input logic bv, input logic [AW-1:0] ba, input logic [63:0] bd, input logic bcm,
                       input logic ee, input logic fi);
        @(negedge clk);
        a_vld = av; a_addr = aa; a_data = ad; a_cmpl = ac;
        b_vld = bv; b_addr = ba; b_data = bd; b_cmpl = bcm;
        ext_err = ee; inj_fire = fi;
        @(posedge clk);
    endtask

    task automatic upd(input int a, input logic [63:0] d, input logic c, input logic fi);
        cyc(1, AW'(a), d, c, 1, AW'(a), d, c, 0, fi);
    endtask

    task automatic quiet(input int n, input logic fi);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, 0, '0, '0, 0, 0, fi);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        a_vld = 0; b_vld = 0; a_cmpl = 0; b_cmpl = 0; ext_err = 0; inj_fire = 0; inj_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < NE; i++) model[i] = '0;
    endtask

    task automatic start_ev();
        ev_n = 0;
        log_seen = 0;
    endtask

    task automatic wait_log(input int maxc);
        for (int i = 0; i < maxc && !log_seen; i++) @(negedge clk);
    endtask

    // full recovery stream: three steps in order, then every entry ascending
    task automatic chk_replay(input string tag);
        bit ok;
        int bad;
        ok = (ev_n == 3 + NE) && ev_kind[0] == 1 && ev_kind[1] == 2 && ev_kind[2] == 3;
        bad = -1;
        for (int k = 0; k < NE && ok; k++) begin
            if (ev_kind[3+k] != 4 || ev_addr[3+k] != k || ev_data[3+k] !== model[k]) begin
                ok = 0; bad = k;
            end
        end
        chk(ok, tag, longint'(bad), longint'(ev_n));
    endtask

    task automatic t_reset();
        chk(!drain_req && !purge_req && !reset_req, "R5 reset no request", drain_req, 0);
        chk(!bc_vld, "R2 reset bc_vld", bc_vld, 0);
        chk(!checkstop, "R9 reset checkstop", checkstop, 0);
        chk(!irq_pend && !log_vld, "R7 reset irq/log", irq_pend, 0);
    endtask

    task automatic t_commit();
        start_ev();
        upd(1, 64'hA1, 0, 0);
        upd(2, 64'hB2, 0, 0);
        quiet(4, 0);
        chk(ev_n == 0, "R2 no write before completion", ev_n, 0);
        upd(3, 64'hC3, 1, 0);
        quiet(5, 0);
        chk(ev_n == 3 && ev_addr[0] == 1 && ev_addr[1] == 2 && ev_addr[2] == 3 &&
            ev_data[0] == 64'hA1 && ev_data[1] == 64'hB2 && ev_data[2] == 64'hC3,
            "R2 commit order", ev_n, 3);
        model[1] = 64'hA1; model[2] = 64'hB2; model[3] = 64'hC3;
        start_ev();
        upd(4, 64'h1111, 0, 0);
        upd(4, 64'h2222, 1, 0);
        quiet(4, 0);
        chk(ev_n == 2 && ev_data[1] == 64'h2222, "R2 same address twice", ev_n, 2);
        model[4] = 64'h2222;
    endtask

    task automatic t_miscompare();
        start_ev();
        upd(5, 64'hDEAD, 0, 0);
        cyc(1, AW'(6), 64'h5, 0, 1, AW'(6), 64'h7, 0, 0, 0);
        quiet(1, 0);
        wait_log(200);
        chk(log_seen, "R7 log after miscompare", log_seen, 1);
        chk_replay("R1 R3 R5 R6 data miscompare replay");
        chk(log_cause_c == 3'b001, "R7 cause miscompare", log_cause_c, 3'b001);
        chk(log_corr_c == 0, "R7 corrected count", log_corr_c, 0);
        @(negedge clk);
        chk(irq_pend, "R7 irq pending", irq_pend, 1);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        chk(!irq_pend, "R7 irq cleared", irq_pend, 0);
    endtask

    task automatic t_block();
        start_ev();
        upd(8, 64'hBEEF, 1, 0);
        cyc(0, '0, '0, 0, 0, '0, '0, 0, 1, 0);
        quiet(1, 0);
        wait_log(200);
        chk_replay("R4 completed entry blocked and discarded");
        chk(log_cause_c == 3'b010, "R7 cause external", log_cause_c, 3'b010);
    endtask

    task automatic t_overflow();
        start_ev();
        for (int i = 0; i < 8; i++) upd(9, 64'h900 + i, (i == 7), 0);
        quiet(12, 0);
        chk(ev_n == 8 && ev_kind[0] == 4 && ev_data[7] == 64'h907, "R8 eight updates commit", ev_n, 8);
        model[9] = 64'h907;
        start_ev();
        for (int i = 0; i < 9; i++) upd(10, 64'hA00 + i, 0, 0);
        quiet(1, 0);
        wait_log(200);
        chk_replay("R8 ninth update overflows");
        chk(log_cause_c == 3'b100, "R8 cause overflow", log_cause_c, 3'b100);
    endtask

    task automatic t_cmpl_mis();
        start_ev();
        cyc(0, '0, '0, 1, 0, '0, '0, 0, 0, 0);
        quiet(1, 0);
        chk(ev_n >= 1 && ev_kind[0] == 1, "R1 completion strobe miscompare", ev_n, 1);
        wait_log(200);
        chk(log_seen && log_cause_c == 3'b001, "R1 completion cause", log_cause_c, 3'b001);
    endtask

    task automatic t_inj_pulse();
        inj_mode = 3'd1;
        start_ev();
        upd(11, 64'hB0B0, 1, 1);
        quiet(1, 0);
        inj_mode = 3'd0;
        wait_log(200);
        chk_replay("R12 forced miscompare discards update");
        chk(log_cause_c == 3'b001, "R12 forced cause", log_cause_c, 3'b001);
    endtask

    task automatic t_inj_random();
        bit seen;
        seen = 0;
        start_ev();
        inj_mode = 3'd2;
        for (int i = 0; i < 64 && !seen; i++) begin
            quiet(1, 0);
            @(negedge clk);
            seen = drain_req;
        end
        inj_mode = 3'd0;
        chk(seen, "R12 random miscompare", seen, 1);
        wait_log(200);
        chk(log_seen && log_cause_c == 3'b001, "R12 random cause", log_cause_c, 3'b001);
    endtask

    task automatic t_single_flip();
        inj_mode = 3'd3;
        upd(12, 64'h1234_5678_9ABC_DEF0, 1, 1);
        quiet(3, 1);
        quiet(1, 0);
        inj_mode = 3'd0;
        model[12] = 64'h1234_5678_9ABC_DEF0;
        start_ev();
        cyc(0, '0, '0, 0, 0, '0, '0, 0, 1, 0);
        quiet(1, 0);
        wait_log(200);
        chk_replay("R10 corrected data broadcast");
        chk(log_corr_c == 1, "R10 one correction", log_corr_c, 1);
        start_ev();
        cyc(0, '0, '0, 0, 0, '0, '0, 0, 1, 0);
        quiet(1, 0);
        wait_log(200);
        chk(log_seen && log_corr_c == 0, "R10 written back fixed", log_corr_c, 0);
    endtask

    task automatic t_double_flip();
        inj_mode = 3'd4;
        upd(13, 64'h5555, 1, 1);
        quiet(3, 1);
        quiet(1, 0);
        inj_mode = 3'd0;
        start_ev();
        cyc(0, '0, '0, 0, 0, '0, '0, 0, 1, 0);
        quiet(40, 0);
        chk(checkstop, "R11 checkstop on double error", checkstop, 1);
        chk(ev_n == 3 + 13 && ev_addr[ev_n-1] == 12, "R11 replay stops before bad entry", ev_n, 16);
        chk(!log_seen, "R11 no log record", log_seen, 0);
        quiet(10, 0);
        chk(checkstop && ev_n == 16, "R9 checkstop sticky", checkstop, 1);
    endtask

    task automatic t_timeout();
        ack_on = 0;
        start_ev();
        cyc(0, '0, '0, 0, 0, '0, '0, 0, 1, 0);
        quiet(10, 0);
        chk(!checkstop && drain_req, "R9 no checkstop before timeout", checkstop, 0);
        quiet(15, 0);
        chk(checkstop && !drain_req, "R9 checkstop after timeout", checkstop, 1);
        chk(ev_n == 1, "R9 no later request", ev_n, 1);
        ack_on = 1;
    endtask

    initial begin
        for (int i = 0; i < NE; i++) model[i] = '0;
        do_reset();
        @(negedge clk);
        t_reset();
        t_commit();
        t_miscompare();
        t_block();
        t_overflow();
        t_cmpl_mis();
        t_inj_pulse();
        t_inj_random();
        t_single_flip();
        t_double_flip();
        do_reset();
        t_timeout();
        do_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            ncheck++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
            $finish;
        end
    end
endmodule